// File: doc/BRIEF.md
# Line Fill Miss Buffer

This block sits between a first-level data cache and the next memory level. It is the only route by which lines move between the two. It holds a small, fully associative set of entries, and each entry covers one whole cache line. A load or store that misses in the L1 presents its line address here. Hits never reach the block. If a live entry already covers that line, the request joins it. Otherwise a free entry is claimed and one downstream request goes out: a shared read for loads, or an ownership request for stores. A store that found its line in the L1 in Shared state asks only for an ownership upgrade, and the response to that request carries no data.

Store bytes can be written into an entry while its miss is outstanding, so the store buffer slot that produced them can be released early. Each entry keeps a per-byte mask of the store bytes it holds. When the downstream response arrives, returned bytes fill only the positions the mask does not cover. The finished line is then offered to the L1 together with a write mask and its final coherence state. The entry is released once the L1 accepts the fill.

When every entry is busy and the request matches none of them, the block stalls the requester. It also stalls when a store joins an entry that can no longer be turned into an ownership request.

Top module: `miss_fill_buf`

## Requirements
- R1: A load miss to a line with no live entry claims a free entry and issues one downstream request with `dn_own`=0, `dn_upgrade`=0 and the line address. After the response, the fill carries the returned bytes with an all-ones mask. The fill state is 1 (Shared) when `rsp_excl`=0 and 2 (Exclusive) when `rsp_excl`=1, provided no store bytes were merged.
- R2: A store miss with `req_hit_shared`=0 claims an entry and issues its downstream request with `dn_own`=1 and `dn_upgrade`=0.
- R3: A request whose line matches a live entry claims no new entry and issues no second downstream request. No two live entries ever hold the same line.
- R4: A store with `req_hit_shared`=1 that matches no entry issues `dn_own`=1 and `dn_upgrade`=1. The response for it carries no data. Its fill mask equals the store byte mask, and the fill state is 3.
- R5: No fill is offered for an entry before its downstream response has been received, and this applies to upgrades as well.
- R6: In the filled line, each byte whose store mask bit is set (bit b covers data bits 8b+7..8b) holds the stored byte, and every other byte holds the returned byte. The fill state is 3 (Modified) whenever any store byte is held.
- R7: A store to a line whose entry has already issued an ownership request is accepted without a stall. Its bytes merge into that entry and no new downstream request is issued.
- R8: A store to the line of a load entry that has not yet issued turns that entry's request into an ownership request (`dn_own`=1).
- R9: A store to a line whose entry has issued a shared request, or whose entry is waiting to fill, is stalled.
- R10: When all entries are live and the request matches none of them, `req_stall`=1. A load that matches a live entry is still accepted.
- R11: `fill_valid` stays high until `fill_ready` is seen. The entry can be claimed again from the cycle after its fill is accepted.
- R12: When several entries wait to issue or to fill, the lowest-numbered entry goes first, and `dn_id` names that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | L1 miss request present |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_hit_shared | input | 1 | Store found the line in L1 Shared (upgrade only) |
| req_line | input | AW | Line address |
| req_be | input | LB | Store byte mask |
| req_data | input | LB*8 | Store data, byte b at bits 8b+7..8b |
| req_stall | output | 1 | Request not accepted this cycle |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request taken |
| dn_own | output | 1 | Ownership requested |
| dn_upgrade | output | 1 | Ownership only, no data wanted |
| dn_line | output | AW | Requested line |
| dn_id | output | IW | Entry number, echoed in the response |
| rsp_valid | input | 1 | Downstream response valid |
| rsp_id | input | IW | Entry the response belongs to |
| rsp_has_data | input | 1 | Response carries line data |
| rsp_excl | input | 1 | Line granted Exclusive |
| rsp_data | input | LB*8 | Returned line |
| fill_valid | output | 1 | Completed line offered to L1 |
| fill_ready | input | 1 | L1 accepts the fill |
| fill_line | output | AW | Line being filled |
| fill_data | output | LB*8 | Merged line |
| fill_mask | output | LB | Bytes the L1 must write |
| fill_state | output | 2 | 1 Shared, 2 Exclusive, 3 Modified |

## Verification
The bench sweeps every store byte mask of a small configuration against an Exclusive response and checks every merged byte and the resulting state. A merge with inverted priority would leak response bytes over store bytes, and an empty mask wrongly marked Modified would show up in the same sweep. Back-to-back misses to one line are checked for a single downstream request. A design that fails to combine them would issue twice or hold duplicate entries. Stores are aimed at lines whose entries are in each state (not yet issued, issued shared, issued for ownership, waiting to fill), so that a missing promotion or a missing stall would leave a store without ownership or silently drop its bytes. The bench also fills the table, checks the stall and the matched-load exception, and checks that an entry is reusable in the cycle after its fill, so that a late release or a wrong release order shows up as a stall or a wrong `dn_id`.

// File: rtl/miss_fill_buf.sv
module miss_fill_buf #(
  parameter int NENT = 10,
  parameter int LB   = 64,
  parameter int AW   = 26,
  localparam int IW  = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_is_store,
  input  logic            req_hit_shared,
  input  logic [AW-1:0]   req_line,
  input  logic [LB-1:0]   req_be,
  input  logic [LB*8-1:0] req_data,
  output logic            req_stall,
  output logic            dn_valid,
  input  logic            dn_ready,
  output logic            dn_own,
  output logic            dn_upgrade,
  output logic [AW-1:0]   dn_line,
  output logic [IW-1:0]   dn_id,
  input  logic            rsp_valid,
  input  logic [IW-1:0]   rsp_id,
  input  logic            rsp_has_data,
  input  logic            rsp_excl,
  input  logic [LB*8-1:0] rsp_data,
  output logic            fill_valid,
  input  logic            fill_ready,
  output logic [AW-1:0]   fill_line,
  output logic [LB*8-1:0] fill_data,
  output logic [LB-1:0]   fill_mask,
  output logic [1:0]      fill_state
);

  typedef enum logic [1:0] {E_FREE, E_ISSUE, E_WAIT, E_FILL} est_t;

  est_t            e_st   [NENT];
  logic [AW-1:0]   e_line [NENT];
  logic            e_own  [NENT];
  logic            e_upg  [NENT];
  logic            e_ex   [NENT];
  logic [LB-1:0]   e_be   [NENT];
  logic [LB*8-1:0] e_data [NENT];

  logic          hit_any, free_any, iss_any, fil_any;
  logic [IW-1:0] hit_ix, free_ix, iss_ix, fil_ix;

  always_comb begin
    hit_any = 1'b0; free_any = 1'b0; iss_any = 1'b0; fil_any = 1'b0;
    hit_ix = '0; free_ix = '0; iss_ix = '0; fil_ix = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (e_st[i] != E_FREE && e_line[i] == req_line) begin hit_any = 1'b1; hit_ix = IW'(i); end
      if (e_st[i] == E_FREE)  begin free_any = 1'b1; free_ix = IW'(i); end
      if (e_st[i] == E_ISSUE) begin iss_any  = 1'b1; iss_ix  = IW'(i); end
      if (e_st[i] == E_FILL)  begin fil_any  = 1'b1; fil_ix  = IW'(i); end
    end
  end

  wire issue_go  = dn_valid && dn_ready;
  wire fill_go   = fill_valid && fill_ready;
  wire store_ok  = (e_st[hit_ix] == E_ISSUE && !(issue_go && iss_ix == hit_ix)) ||
                   (e_st[hit_ix] == E_WAIT && e_own[hit_ix]);

  assign req_stall = req_valid && (hit_any ? (req_is_store && !store_ok) : !free_any);

  wire accept = req_valid && !req_stall;
  wire alloc  = accept && !hit_any;
  wire merge  = accept && hit_any && req_is_store;

  assign dn_valid   = iss_any;
  assign dn_own     = e_own[iss_ix];
  assign dn_upgrade = e_upg[iss_ix];
  assign dn_line    = e_line[iss_ix];
  assign dn_id      = iss_ix;

  assign fill_valid = fil_any;
  assign fill_line  = e_line[fil_ix];
  assign fill_data  = e_data[fil_ix];
  assign fill_mask  = e_upg[fil_ix] ? e_be[fil_ix] : '1;
  assign fill_state = (|e_be[fil_ix]) ? 2'd3 : (e_ex[fil_ix] ? 2'd2 : 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) e_st[i] <= E_FREE;
    end else begin
      for (int i = 0; i < NENT; i++) begin
        if (alloc && free_ix == IW'(i)) begin
          e_st[i]   <= E_ISSUE;
          e_line[i] <= req_line;
          e_own[i]  <= req_is_store;
          e_upg[i]  <= req_is_store && req_hit_shared;
          e_ex[i]   <= 1'b0;
          e_be[i]   <= req_is_store ? req_be : '0;
          e_data[i] <= req_data;
        end else begin
          if (merge && hit_ix == IW'(i)) begin
            e_own[i] <= 1'b1;
            e_be[i]  <= e_be[i] | req_be;
          end
          if (issue_go && iss_ix == IW'(i)) e_st[i] <= E_WAIT;
          if (rsp_valid && rsp_id == IW'(i) && e_st[i] == E_WAIT) begin
            e_st[i] <= E_FILL;
            e_ex[i] <= rsp_excl;
          end
          if (fill_go && fil_ix == IW'(i)) e_st[i] <= E_FREE;
          for (int b = 0; b < LB; b++) begin
            if (merge && hit_ix == IW'(i) && req_be[b])
              e_data[i][b*8 +: 8] <= req_data[b*8 +: 8];
            else if (rsp_valid && rsp_id == IW'(i) && e_st[i] == E_WAIT &&
                     rsp_has_data && !e_be[i][b])
              e_data[i][b*8 +: 8] <= rsp_data[b*8 +: 8];
          end
        end
      end
    end
  end

  logic dup_line;
  always_comb begin
    dup_line = 1'b0;
    for (int i = 0; i < NENT; i++)
      for (int j = i + 1; j < NENT; j++)
        if (e_st[i] != E_FREE && e_st[j] != E_FREE && e_line[i] == e_line[j]) dup_line = 1'b1;
  end

  AST_NO_DUP_LINE: assert property (@(posedge clk) disable iff (!rst_n) !dup_line); // R3
  AST_RSP_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> e_st[rsp_id] == E_WAIT); // R5
  AST_UPG_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && e_upg[rsp_id]) |-> !rsp_has_data); // R4
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=> fill_valid); // R11
  AST_FREE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> e_st[$past(fil_ix)] == E_FREE); // R11

endmodule

// File: tb/miss_fill_buf_tb.sv
module miss_fill_buf_tb;
  localparam int NENT = 4, LB = 8, AW = 8, IW = 2, DW = LB * 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_is_store = 0, req_hit_shared = 0;
  logic [AW-1:0] req_line = '0;
  logic [LB-1:0] req_be = '0;
  logic [DW-1:0] req_data = '0;
  logic req_stall;
  logic dn_valid, dn_ready = 0, dn_own, dn_upgrade;
  logic [AW-1:0] dn_line;
  logic [IW-1:0] dn_id;
  logic rsp_valid = 0, rsp_has_data = 0, rsp_excl = 0;
  logic [IW-1:0] rsp_id = '0;
  logic [DW-1:0] rsp_data = '0;
  logic fill_valid, fill_ready = 0;
  logic [AW-1:0] fill_line;
  logic [DW-1:0] fill_data;
  logic [LB-1:0] fill_mask;
  logic [1:0] fill_state;

  int checks = 0, fails = 0;
  bit done = 0;

  miss_fill_buf #(.NENT(NENT), .LB(LB), .AW(AW)) u_dut (.*);

  always #2 clk = ~clk;

  function automatic [DW-1:0] bx(input [LB-1:0] m);
    for (int b = 0; b < LB; b++) bx[b*8 +: 8] = m[b] ? 8'hFF : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%h exp=%h", what, act, exp); end
  endtask

  task automatic send(input bit st, input [AW-1:0] line, input bit hs, input [LB-1:0] be,
                      input [DW-1:0] d, output bit stalled);
    @(negedge clk);
    req_valid = 1; req_is_store = st; req_line = line; req_hit_shared = hs; req_be = be; req_data = d;
    #1 stalled = req_stall;
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic issue(input bit own, input bit upg, input [AW-1:0] line, input [IW-1:0] id, input string tag);
    @(negedge clk);
    chk(dn_valid, {tag, " dn_valid"}, 64'(dn_valid), 1);
    chk(dn_own == own && dn_upgrade == upg, {tag, " own/upg"}, {dn_own, dn_upgrade}, {own, upg});
    chk(dn_line == line && dn_id == id, {tag, " line/id"}, {dn_line, 6'd0, dn_id}, {line, 6'd0, id});
    dn_ready = 1; @(posedge clk); #1 dn_ready = 0;
  endtask

  task automatic respond(input [IW-1:0] id, input bit hd, input bit ex, input [DW-1:0] d);
    @(negedge clk);
    rsp_valid = 1; rsp_id = id; rsp_has_data = hd; rsp_excl = ex; rsp_data = d;
    @(posedge clk); #1 rsp_valid = 0;
  endtask

  task automatic fillchk(input [AW-1:0] line, input [DW-1:0] d, input [LB-1:0] m,
                         input [1:0] st, input string tag);
    @(negedge clk);
    chk(fill_valid && fill_line == line, {tag, " fill line"}, {fill_valid, 7'd0, fill_line}, {8'd1, line});
    chk(fill_mask == m, {tag, " fill mask"}, 64'(fill_mask), 64'(m));
    chk((fill_data & bx(m)) == (d & bx(m)), {tag, " fill data"}, fill_data & bx(m), d & bx(m));
    chk(fill_state == st, {tag, " fill state"}, 64'(fill_state), 64'(st));
    fill_ready = 1; @(posedge clk); #1 fill_ready = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit s;
    logic [DW-1:0] sd, rd, ex;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!dn_valid && !fill_valid && !req_stall, "reset idle", {dn_valid, fill_valid, req_stall}, 0);

    // R1 load miss, shared response, fill held until ready (R11)
    send(0, 8'h05, 0, 8'h00, 0, s);
    chk(!s, "R1 no stall", s, 0);
    issue(0, 0, 8'h05, 0, "R1");
    respond(0, 1, 0, 64'h0807060504030201);
    @(negedge clk);
    chk(fill_valid, "R11 fill held", fill_valid, 1);
    fillchk(8'h05, 64'h0807060504030201, 8'hFF, 1, "R1");

    // R3 duplicate loads combine
    send(0, 8'h22, 0, 0, 0, s);
    send(0, 8'h22, 0, 0, 0, s);
    chk(!s, "R3 dup accepted", s, 0);
    issue(0, 0, 8'h22, 0, "R3");
    @(negedge clk);
    chk(!dn_valid, "R3 single request", dn_valid, 0);
    respond(0, 1, 1, 64'h1122334455667788);
    fillchk(8'h22, 64'h1122334455667788, 8'hFF, 2, "R1 excl");

    // R9 store to issued shared entry, then to filling entry
    send(0, 8'h20, 0, 0, 0, s);
    issue(0, 0, 8'h20, 0, "R9");
    send(1, 8'h20, 0, 8'h01, 64'hAA, s);
    chk(s, "R9 stall issued shared", s, 1);
    respond(0, 1, 0, 64'h5555);
    send(1, 8'h20, 0, 8'h01, 64'hAA, s);
    chk(s, "R9 stall filling", s, 1);
    fillchk(8'h20, 64'h5555, 8'hFF, 1, "R9");

    // R8 store promotes unissued load entry
    send(0, 8'h30, 0, 0, 0, s);
    send(1, 8'h30, 0, 8'h01, 64'hAA, s);
    chk(!s, "R8 accepted", s, 0);
    issue(1, 0, 8'h30, 0, "R8");
    respond(0, 1, 1, 64'h1111111111111111);
    fillchk(8'h30, 64'h11111111111111AA, 8'hFF, 3, "R8");

    // R2/R7 store miss then merge while outstanding
    send(1, 8'h40, 0, 8'h03, 64'h000000000000BEEF, s);
    issue(1, 0, 8'h40, 0, "R2");
    send(1, 8'h40, 0, 8'h30, 64'h0000CAFE00000000, s);
    chk(!s, "R7 accepted", s, 0);
    @(negedge clk);
    chk(!dn_valid, "R7 no new request", dn_valid, 0);
    respond(0, 1, 1, 64'h7777777777777777);
    fillchk(8'h40, 64'h7777CAFE7777BEEF, 8'hFF, 3, "R6/R7");

    // R4/R5 upgrade
    send(1, 8'h50, 1, 8'hF0, 64'hDEADBEEF00000000, s);
    issue(1, 1, 8'h50, 0, "R4");
    @(negedge clk); @(negedge clk);
    chk(!fill_valid, "R5 waits for ack", fill_valid, 0);
    respond(0, 0, 1, 64'h0);
    fillchk(8'h50, 64'hDEADBEEF00000000, 8'hF0, 3, "R4");

    // R10/R12/R11 full table
    for (int k = 0; k < 4; k++) begin
      send(0, AW'(8'h10 + k), 0, 0, 0, s);
      chk(!s, "R10 fill table", s, 0);
    end
    send(0, 8'h14, 0, 0, 0, s);
    chk(s, "R10 full stall", s, 1);
    send(0, 8'h12, 0, 0, 0, s);
    chk(!s, "R10 matched load accepted", s, 0);
    for (int k = 0; k < 4; k++) issue(0, 0, AW'(8'h10 + k), IW'(k), "R12 issue order");
    for (int k = 3; k >= 0; k--) respond(IW'(k), 1, 0, 64'(k + 100));
    fillchk(8'h10, 64'd100, 8'hFF, 1, "R12 fill order");
    send(0, 8'h14, 0, 0, 0, s);
    chk(!s, "R11 reuse next cycle", s, 0);
    for (int k = 1; k < 4; k++) fillchk(AW'(8'h10 + k), 64'(k + 100), 8'hFF, 1, "R12 fill order");
    issue(0, 0, 8'h14, 0, "R11 reused entry");
    respond(0, 1, 0, 64'h99);
    fillchk(8'h14, 64'h99, 8'hFF, 1, "R11");

    // R6 sweep of all store masks
    for (int m = 0; m < 256; m++) begin
      sd = {8{8'(m)}} ^ 64'h0F1E2D3C4B5A6978;
      rd = 64'hF0E1D2C3B4A59687 + 64'(m);
      ex = (sd & bx(8'(m))) | (rd & ~bx(8'(m)));
      send(1, 8'h60, 0, 8'(m), sd, s);
      issue(1, 0, 8'h60, 0, "R2 sweep");
      respond(0, 1, 1, rd);
      fillchk(8'h60, ex, 8'hFF, (m != 0) ? 2'd3 : 2'd2, "R6 sweep");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule